// File: doc/BRIEF.md
# Four-phase handshake buffer controller

This block is the control part of a single-stage buffer placed between two four-phase (return-to-zero) request/acknowledge channels. A producer on the left raises a request and waits for an acknowledge. The block passes that request on to a consumer on the right. It completes the left exchange only after the right side has acknowledged. The data latches steered by these signals are not part of the block.

The controller is a clocked state machine. Both incoming handshake wires first pass through a parameterised synchronizer chain. Each side has its own four-phase sequencer. Two one-bit token registers stand for the two dependencies between the sides: "a left request has arrived and may be forwarded" and "the right side has acknowledged, so the left acknowledge may drop". Several reachable situations show the same values on all four wires but need different next moves. Explicit phase and token state tells them apart. After reset all four wires are low.

Top module: `hs_buf_ctrl`

## Requirements
- R1: While reset is asserted, and afterwards as long as lreq_i stays low, lack_o and rreq_o are both 0.
- R2: On the left channel the events follow lreq_i rise, lack_o rise, lreq_i fall, lack_o fall. lack_o rises only while the synchronized lreq_i is 1 and falls only while it is 0.
- R3: On the right channel the events follow rreq_o rise, rack_i rise, rreq_o fall, rack_i fall. rreq_o rises only while the synchronized rack_i is 0 and falls only while it is 1.
- R4: The k-th rise of rreq_o comes after the k-th rise of lreq_i. rreq_o never rises without a left request that has not yet been forwarded.
- R5: The k-th fall of lack_o comes after the k-th rise of rack_i. Until rack_i rises, lack_o stays 1 however long lreq_i has been low.
- R6: From the idle state, lack_o and rreq_o both rise on clock edge SYNC_STAGES+2 counted from the first edge that sees lreq_i at 1.
- R7: If lreq_i is already low when rack_i rises, lack_o and rreq_o both fall on the same edge, SYNC_STAGES+2 edges after the first edge that sees rack_i at 1.
- R8: An output whose enabling condition has been reached changes on the next clock edge, with no further dependence on the inputs.
- R9: A new left request that arrives while rack_i is still high is acknowledged on lack_o without waiting. Its rreq_o rise waits for rack_i to fall and then comes SYNC_STAGES+2 edges after the first edge that sees rack_i at 0.
- R10: Over a run of back-to-back transfers with random delays on both sides, every transfer completes. The counts of rises and falls of all four wires end up equal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lreq_i | input | 1 | Left channel request from the producer |
| lack_o | output | 1 | Left channel acknowledge to the producer |
| rreq_o | output | 1 | Right channel request to the consumer |
| rack_i | input | 1 | Right channel acknowledge from the consumer |

## Verification
Two pairs of events can land on the same clock edge. The acknowledge to the left and the request to the right rise together at the start of a transfer. Both outputs fall together at the end of a transfer when the producer has already released its request before the consumer acknowledges. The bench provokes the second case by dropping lreq_i, waiting, and only then raising rack_i. It checks that neither output has moved after SYNC_STAGES+1 edges and that both have fallen after SYNC_STAGES+2. A separate scenario holds rack_i high across the next left request to confirm that the left side runs ahead while rreq_o waits.

// File: rtl/hs_buf_pkg.sv
package hs_buf_pkg;

  typedef enum logic [1:0] {
    L_IDLE = 2'd0,  // waiting for request
    L_SEEN = 2'd1,  // request seen, acknowledge due
    L_HELD = 2'd2,  // acknowledged, waiting for release
    L_DROP = 2'd3   // released, waiting for right side ack
  } lphase_t;

  typedef enum logic [1:0] {
    R_IDLE = 2'd0,  // waiting for forward token
    R_WAIT = 2'd1,  // request out, waiting for ack
    R_DONE = 2'd2,  // ack seen, request drop due
    R_REL  = 2'd3   // request dropped, waiting for ack low
  } rphase_t;

endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/hs_token.sv
// One-bit dependency token between the two channel sequencers.
module hs_token (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic produce_i,
  input  logic consume_i,
  output logic full_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) full_o <= 1'b0;
    else         full_o <= produce_i | (full_o & ~consume_i);
  end

endmodule

// File: rtl/hs_left_ctl.sv
module hs_left_ctl
  import hs_buf_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    req_s_i,
  input  logic    release_ok_i,
  output logic    ack_o,
  output logic    seen_o,
  output logic    done_o,
  output lphase_t phase_o
);

  lphase_t phase_q, phase_d;
  logic    ack_d;

  always_comb begin
    phase_d = phase_q;
    ack_d   = ack_o;
    seen_o  = 1'b0;
    done_o  = 1'b0;
    case (phase_q)
      L_IDLE: if (req_s_i) begin
        phase_d = L_SEEN;
        seen_o  = 1'b1;
      end
      L_SEEN: begin
        phase_d = L_HELD;
        ack_d   = 1'b1;
      end
      L_HELD: if (!req_s_i) phase_d = L_DROP;
      L_DROP: if (release_ok_i) begin
        phase_d = L_IDLE;
        ack_d   = 1'b0;
        done_o  = 1'b1;
      end
      default: phase_d = L_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= L_IDLE;
      ack_o   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      ack_o   <= ack_d;
    end
  end

  assign phase_o = phase_q;

endmodule

// File: rtl/hs_right_ctl.sv
module hs_right_ctl
  import hs_buf_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    fwd_ok_i,
  input  logic    ack_s_i,
  output logic    req_o,
  output logic    take_o,
  output logic    acked_o,
  output rphase_t phase_o
);

  rphase_t phase_q, phase_d;
  logic    req_d;

  always_comb begin
    phase_d = phase_q;
    req_d   = req_o;
    take_o  = 1'b0;
    acked_o = 1'b0;
    case (phase_q)
      R_IDLE: if (fwd_ok_i) begin
        phase_d = R_WAIT;
        req_d   = 1'b1;
        take_o  = 1'b1;
      end
      R_WAIT: if (ack_s_i) begin
        phase_d = R_DONE;
        acked_o = 1'b1;
      end
      R_DONE: begin
        phase_d = R_REL;
        req_d   = 1'b0;
      end
      R_REL: if (!ack_s_i) phase_d = R_IDLE;
      default: phase_d = R_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= R_IDLE;
      req_o   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      req_o   <= req_d;
    end
  end

  assign phase_o = phase_q;

endmodule

// File: rtl/hs_buf_ctrl.sv
module hs_buf_ctrl
  import hs_buf_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lreq_i,
  output logic lack_o,
  output logic rreq_o,
  input  logic rack_i
);

  localparam int SyncW = 2;

  logic [SyncW-1:0] sync_q;
  logic    lreq_s, rack_s;
  logic    l_seen, l_done, r_take, r_acked;
  logic    fwd_full, rel_full;
  lphase_t lphase;
  rphase_t rphase;

  hs_sync #(.STAGES(SYNC_STAGES), .WIDTH(SyncW)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({rack_i, lreq_i}),
    .q_o   (sync_q)
  );

  assign lreq_s = sync_q[0];
  assign rack_s = sync_q[1];

  // left request seen -> right request allowed
  hs_token u_fwd_tok (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .produce_i(l_seen),
    .consume_i(r_take),
    .full_o   (fwd_full)
  );

  // right acknowledge seen -> left acknowledge may drop
  hs_token u_rel_tok (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .produce_i(r_acked),
    .consume_i(l_done),
    .full_o   (rel_full)
  );

  hs_left_ctl u_left (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_s_i     (lreq_s),
    .release_ok_i(rel_full),
    .ack_o       (lack_o),
    .seen_o      (l_seen),
    .done_o      (l_done),
    .phase_o     (lphase)
  );

  hs_right_ctl u_right (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fwd_ok_i(fwd_full),
    .ack_s_i (rack_s),
    .req_o   (rreq_o),
    .take_o  (r_take),
    .acked_o (r_acked),
    .phase_o (rphase)
  );

endmodule

// File: rtl/hs_buf_ctrl_chk.sv
module hs_buf_ctrl_chk
  import hs_buf_pkg::*;
(
  input logic    clk_i,
  input logic    rst_ni,
  input logic    lreq_s,
  input logic    rack_s,
  input logic    lack_o,
  input logic    rreq_o,
  input lphase_t lphase,
  input rphase_t rphase
);

  logic lreq_q, rack_q, lack_q, rreq_q;
  logic pend_fwd, pend_rel;

  // independent bookkeeping of outstanding cross dependencies
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lreq_q   <= 1'b0;
      rack_q   <= 1'b0;
      lack_q   <= 1'b0;
      rreq_q   <= 1'b0;
      pend_fwd <= 1'b0;
      pend_rel <= 1'b0;
    end else begin
      lreq_q   <= lreq_s;
      rack_q   <= rack_s;
      lack_q   <= lack_o;
      rreq_q   <= rreq_o;
      pend_fwd <= (lreq_s & ~lreq_q) | (pend_fwd & ~(rreq_o & ~rreq_q));
      pend_rel <= (rack_s & ~rack_q) | (pend_rel & ~(~lack_o & lack_q));
    end
  end

  AST_ACK_RISE_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lack_o) |-> lreq_s); // R2
  AST_ACK_FALL_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lack_o) |-> !lreq_s); // R2
  AST_RREQ_RISE_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rreq_o) |-> !rack_s); // R3
  AST_RREQ_FALL_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rreq_o) |-> rack_s); // R3
  AST_RREQ_AFTER_LREQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rreq_o) |-> pend_fwd); // R4
  AST_ACK_FALL_AFTER_RACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lack_o) |-> pend_rel); // R5
  AST_ACK_PERSIST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lphase == L_SEEN) |=> $rose(lack_o)); // R8
  AST_RREQ_PERSIST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rphase == R_DONE) |=> $fell(rreq_o)); // R8

endmodule

bind hs_buf_ctrl hs_buf_ctrl_chk u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .lreq_s(lreq_s),
  .rack_s(rack_s),
  .lack_o(lack_o),
  .rreq_o(rreq_o),
  .lphase(lphase),
  .rphase(rphase)
);

// File: tb/hs_buf_ctrl_test.sv
module hs_buf_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int SYNC       = 2;
  localparam int LAT        = SYNC + 2;
  localparam int N_STREAM   = 40;
  localparam int WDOG       = 100000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic lreq_i = 1'b0;
  logic lack_o, rreq_o, rack_i;
  logic resp_en = 1'b0;
  logic auto_rack = 1'b0;
  logic man_rack = 1'b0;

  int n_checks = 0;
  int n_fail = 0;
  int n_lr = 0, n_lf = 0, n_ar = 0, n_af = 0;
  int n_rr = 0, n_rf = 0, n_kr = 0, n_kf = 0;

  assign rack_i = resp_en ? auto_rack : man_rack;

  always #(CLK_PERIOD/2) clk = ~clk;

  hs_buf_ctrl #(.SYNC_STAGES(SYNC)) uut (
    .clk_i (clk),
    .rst_ni(rst_ni),
    .lreq_i(lreq_i),
    .lack_o(lack_o),
    .rreq_o(rreq_o),
    .rack_i(rack_i)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // event-order monitor against the reference sequence of both channels
  logic p_l = 0, p_a = 0, p_r = 0, p_k = 0;
  always @(negedge clk) begin
    if (rst_ni) begin
      if (lreq_i && !p_l) n_lr++;
      if (!lreq_i && p_l) n_lf++;
      if (rack_i && !p_k) n_kr++;
      if (!rack_i && p_k) n_kf++;
      if (lack_o && !p_a) begin
        chk(n_lr == n_ar + 1, "R2 ack rise after req rise", n_lr, n_ar + 1);
        n_ar++;
      end
      if (!lack_o && p_a) begin
        chk(n_lf == n_af + 1, "R2 ack fall after req fall", n_lf, n_af + 1);
        chk(n_kr >= n_af + 1, "R5 ack fall after rack rise", n_kr, n_af + 1);
        n_af++;
      end
      if (rreq_o && !p_r) begin
        chk(n_kf == n_rr, "R3 rreq rise after rack fall", n_kf, n_rr);
        chk(n_lr >= n_rr + 1, "R4 rreq rise after req rise", n_lr, n_rr + 1);
        n_rr++;
      end
      if (!rreq_o && p_r) begin
        chk(n_kr == n_rf + 1, "R3 rreq fall after rack rise", n_kr, n_rf + 1);
        n_rf++;
      end
    end
    p_l = lreq_i; p_a = lack_o; p_r = rreq_o; p_k = rack_i;
  end

  // automatic right-side responder with random delays
  initial begin
    forever begin
      @(negedge clk);
      if (resp_en) begin
        if (rreq_o && !auto_rack) begin
          repeat ($urandom_range(0, 7)) @(negedge clk);
          auto_rack = 1'b1;
        end else if (!rreq_o && auto_rack) begin
          repeat ($urandom_range(0, 7)) @(negedge clk);
          auto_rack = 1'b0;
        end
      end
    end
  end

  task automatic t_reset;
    cyc(3);
    chk(lack_o == 0, "R1 lack in reset", int'(lack_o), 0);
    chk(rreq_o == 0, "R1 rreq in reset", int'(rreq_o), 0);
    rst_ni = 1'b1;
    cyc(10);
    chk(lack_o == 0, "R1 lack idle", int'(lack_o), 0);
    chk(rreq_o == 0, "R1 rreq idle", int'(rreq_o), 0);
  endtask

  // latency, held acknowledge, joint release on one edge
  task automatic t_latency_release;
    lreq_i = 1'b1;
    cyc(LAT - 1);
    chk(lack_o == 0, "R6 lack before latency", int'(lack_o), 0);
    chk(rreq_o == 0, "R6 rreq before latency", int'(rreq_o), 0);
    cyc(1);
    chk(lack_o == 1, "R6 lack at latency", int'(lack_o), 1);
    chk(rreq_o == 1, "R6 rreq with lack same edge", int'(rreq_o), 1);
    lreq_i = 1'b0;
    cyc(20);
    chk(lack_o == 1, "R5 lack held without rack", int'(lack_o), 1);
    chk(rreq_o == 1, "R8 rreq held without rack", int'(rreq_o), 1);
    man_rack = 1'b1;
    cyc(LAT - 1);
    chk(lack_o == 1, "R7 lack before release edge", int'(lack_o), 1);
    chk(rreq_o == 1, "R7 rreq before release edge", int'(rreq_o), 1);
    cyc(1);
    chk(lack_o == 0, "R7 lack falls at release edge", int'(lack_o), 0);
    chk(rreq_o == 0, "R7 rreq falls same edge", int'(rreq_o), 0);
    man_rack = 1'b0;
    cyc(10);
    chk(rreq_o == 0, "R4 no rreq without new req", int'(rreq_o), 0);
    chk(lack_o == 0, "R1 back to idle", int'(lack_o), 0);
  endtask

  // next left request while right ack still high
  task automatic t_overlap;
    lreq_i = 1'b1;
    while (!rreq_o) @(negedge clk);
    man_rack = 1'b1;
    lreq_i = 1'b0;
    while (lack_o || rreq_o) @(negedge clk);
    cyc(2);
    lreq_i = 1'b1;
    cyc(LAT);
    chk(lack_o == 1, "R9 lack rises while rack high", int'(lack_o), 1);
    chk(rreq_o == 0, "R9 rreq waits while rack high", int'(rreq_o), 0);
    cyc(10);
    chk(rreq_o == 0, "R3 rreq stays low with rack high", int'(rreq_o), 0);
    man_rack = 1'b0;
    cyc(LAT - 1);
    chk(rreq_o == 0, "R9 rreq before latency after rack fall", int'(rreq_o), 0);
    cyc(1);
    chk(rreq_o == 1, "R9 rreq at latency after rack fall", int'(rreq_o), 1);
    man_rack = 1'b1;
    lreq_i = 1'b0;
    while (lack_o || rreq_o) @(negedge clk);
    man_rack = 1'b0;
    cyc(LAT + 2);
    chk(lack_o == 0 && rreq_o == 0, "R1 idle after overlap",
        int'({lack_o, rreq_o}), 0);
  endtask

  task automatic t_stream;
    int base_lr = n_lr;
    int base_af = n_af;
    int base_rf = n_rf;
    resp_en = 1'b1;
    for (int i = 0; i < N_STREAM; i++) begin
      cyc($urandom_range(0, 5));
      lreq_i = 1'b1;
      while (!lack_o) @(negedge clk);
      cyc($urandom_range(0, 5));
      lreq_i = 1'b0;
      while (lack_o) @(negedge clk);
    end
    while (rreq_o || rack_i) @(negedge clk);
    cyc(LAT + 2);
    chk(n_lr - base_lr == N_STREAM, "R10 left requests", n_lr - base_lr, N_STREAM);
    chk(n_af - base_af == N_STREAM, "R10 left completions", n_af - base_af, N_STREAM);
    chk(n_rf - base_rf == N_STREAM, "R10 right completions", n_rf - base_rf, N_STREAM);
    chk(n_rr == n_kf && n_kr == n_rr, "R10 right counts balanced", n_kr, n_rr);
    resp_en = 1'b0;
  endtask

  initial begin
    t_reset();
    t_latency_release();
    t_overlap();
    t_stream();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", WDOG, 0);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule